// File: doc/BRIEF.md
# Programmable Delay Tap Controller

This block holds the 5-bit tap setting of a 32-stage wrap-around delay line and updates it on a single synchronous clock. A static parameter sets one of four behaviours: a fixed setting, a setting that can be stepped and restored to a preset, a setting that can be stepped and loaded from a count input, and a loadable setting whose load source is a staging register that software fills ahead of time.

Stepping moves the tap by one position per enabled cycle, with modular wrap at both ends. In the staged mode, many lanes can each receive a new value through their staging registers over several cycles, and a single shared load pulse then moves every lane to its new tap in the same cycle. The tap value is driven straight from its register, so a change is visible right after the edge that makes it. A valid flag tells downstream logic whether the tap holds a defined value.

Top module: `tap_delay_ctrl`

## Requirements
- R1: `tap_out` is 5 bits wide and changes on the same rising edge that updates the tap, with no extra register stage.
- R2: In every mode except fixed, with `load` low and `step_en` high, the tap goes up by one when `step_up` is 1 and down by one when `step_up` is 0, once per cycle.
- R3: With `load` low and `step_en` low, the tap keeps its value whatever `step_up` is.
- R4: Stepping up from 31 gives 0, and stepping down from 0 gives 31.
- R5: When `load` and `step_en` are both high on an edge, the load takes effect and the step is discarded.
- R6: In variable mode (MODE=1), `load` sets the tap to the PRESET parameter.
- R7: In loadable mode (MODE=2), `load` sets the tap to `count_in`.
- R8: In staged mode (MODE=3), `stage_load` copies `count_in` into the staging register, and `load` copies the staging register into the tap. When both are high on the same edge, the tap takes the old staging value.
- R9: In staged mode, `stage_clr` clears the staging register to zero. It wins over `stage_load` on the same edge.
- R10: In fixed mode (MODE=0), the tap always equals PRESET, and `load`, `step_en`, `step_up`, `stage_load`, `stage_clr` and `count_in` have no effect.
- R11: Synchronous active-high `rst` sets the tap to PRESET in modes 0 and 1, and to 0 in modes 2 and 3, where PRESET is ignored. It also clears the staging register.
- R12: After reset, `tap_valid` is 1 in modes 0 and 1. In modes 2 and 3 it is 0 until the first `load`, then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load the tap from the mode's load source |
| step_en | input | 1 | Enable one step per cycle |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| stage_load | input | 1 | Capture `count_in` into the staging register |
| stage_clr | input | 1 | Clear the staging register |
| count_in | input | 5 | Value to load or stage |
| tap_out | output | 5 | Current tap setting |
| tap_valid | output | 1 | Tap holds a defined value |

## Verification
The bench builds four instances side by side, one for each MODE value (0 to 3). Fixed mode uses PRESET 5, variable mode uses PRESET 9, and both loadable modes use PRESET 7, which makes it visible that the loadable modes ignore the preset. All four instances share the same stimulus. This lets one sweep show, in the same cycles, that fixed mode ignores the controls and that each of the other modes responds in its own way. The sweep loads and stages every count value from 0 to 31, and runs long up and down step runs that cross the wrap point in both directions. Separate sequences cover the same-cycle conflicts between load and step, and between staging, clearing and load.

// File: rtl/tap_delay_ctrl.sv
module tap_delay_ctrl #(
  parameter int MODE     = 1,
  parameter int TAP_BITS = 5,
  parameter int PRESET   = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                step_en,
  input  logic                step_up,
  input  logic                stage_load,
  input  logic                stage_clr,
  input  logic [TAP_BITS-1:0] count_in,
  output logic [TAP_BITS-1:0] tap_out,
  output logic                tap_valid
);
  localparam int M_FIXED = 0, M_VAR = 1, M_LOAD = 2, M_PIPE = 3;
  localparam logic [TAP_BITS-1:0] PRESET_V = TAP_BITS'(PRESET);
  localparam logic [TAP_BITS-1:0] RST_TAP  = (MODE >= M_LOAD) ? '0 : PRESET_V;

  logic [TAP_BITS-1:0] tap_q, stage_q, load_src;
  logic                valid_q;

  assign load_src  = (MODE == M_VAR) ? PRESET_V : (MODE == M_LOAD) ? count_in : stage_q;
  assign tap_out   = tap_q;
  assign tap_valid = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q   <= RST_TAP;
      stage_q <= '0;
      valid_q <= (MODE < M_LOAD);
    end else begin
      if (MODE == M_PIPE) begin
        if (stage_clr)       stage_q <= '0;
        else if (stage_load) stage_q <= count_in;
      end
      if (MODE != M_FIXED) begin
        if (load) begin
          tap_q   <= load_src;
          valid_q <= 1'b1;
        end else if (step_en) begin
          tap_q <= step_up ? tap_q + 1'b1 : tap_q - 1'b1;
        end
      end
    end
  end

  generate
    if (MODE == M_FIXED) begin : g_fixed_chk
      assert_fixed_tap_R10: assert property (@(posedge clk) disable iff (rst)
        tap_q == PRESET_V);
    end else begin : g_var_chk
      assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && step_en && step_up) |=> tap_q == TAP_BITS'($past(tap_q) + 1'b1));
      assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && step_en && !step_up) |=> tap_q == TAP_BITS'($past(tap_q) - 1'b1));
      assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && !step_en) |=> $stable(tap_q));
      assert_load_valid_R12: assert property (@(posedge clk) disable iff (rst)
        load |=> tap_valid);
    end
    if (MODE == M_VAR) begin : g_var_load
      assert_preset_load_R6: assert property (@(posedge clk) disable iff (rst)
        load |=> tap_q == PRESET_V);
    end
    if (MODE == M_LOAD) begin : g_cnt_load
      assert_count_load_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> tap_q == $past(count_in));
    end
    if (MODE == M_PIPE) begin : g_pipe_load
      assert_stage_commit_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> tap_q == $past(stage_q));
      assert_stage_clear_R9: assert property (@(posedge clk) disable iff (rst)
        stage_clr |=> stage_q == '0);
    end
  endgenerate
endmodule

// File: tb/tap_delay_ctrl_bench.sv
`timescale 1ns/1ps
module tap_delay_ctrl_bench;
  logic clk = 0, rst = 1, load = 0, step_en = 0, step_up = 0, stage_load = 0, stage_clr = 0;
  logic [4:0] count_in = 0;
  logic [4:0] tap_o [4];
  logic       val_o [4];
  int checks = 0, fails = 0, m_tap [4], m_stage = 0;
  bit m_val [4];
  bit done = 0;
  localparam int PRE [4] = '{5, 9, 7, 7};

  always #2 clk = ~clk;

  for (genvar g = 0; g < 4; g++) begin : g_dut
    tap_delay_ctrl #(.MODE(g), .TAP_BITS(5), .PRESET(PRE[g])) u_tap_delay_ctrl (
      .clk(clk), .rst(rst), .load(load), .step_en(step_en), .step_up(step_up),
      .stage_load(stage_load), .stage_clr(stage_clr), .count_in(count_in),
      .tap_out(tap_o[g]), .tap_valid(val_o[g]));
  end

  task automatic chk(string req, int mode, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s mode %0d: actual %0d expected %0d", req, mode, act, exp);
    end
  endtask

  task automatic cyc(bit r, bit ld, bit en, bit up, bit sl, bit sc, int cv);
    string tag [4];
    @(negedge clk);
    rst = r; load = ld; step_en = en; step_up = up; stage_load = sl; stage_clr = sc; count_in = 5'(cv);
    @(posedge clk);
    for (int m = 0; m < 4; m++) begin
      if (r) begin
        m_tap[m] = (m >= 2) ? 0 : PRE[m]; m_val[m] = (m < 2); tag[m] = "R11";
      end else if (m == 0) tag[m] = "R10";
      else if (ld) begin
        m_tap[m] = (m == 1) ? PRE[1] : (m == 2) ? cv : m_stage;
        m_val[m] = 1;
        tag[m] = en ? "R5" : (m == 1) ? "R6" : (m == 2) ? "R7" : "R8";
      end else if (en) begin
        tag[m] = ((up && m_tap[m] == 31) || (!up && m_tap[m] == 0)) ? "R4" : "R2";
        m_tap[m] = (m_tap[m] + (up ? 1 : 31)) % 32;
      end else tag[m] = "R3";
    end
    if (r || sc) m_stage = 0;
    else if (sl) m_stage = cv;
    #1;
    for (int m = 0; m < 4; m++) begin
      chk(tag[m], m, int'(tap_o[m]), m_tap[m]);
      chk("R12", m, int'(val_o[m]), int'(m_val[m]));
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    // R11 reset values, R12 loadable modes invalid before first load
    cyc(0, 0, 1, 1, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    // R7/R8 sweep every count value; R1 visible right after the edge
    for (int v = 0; v < 32; v++) begin
      cyc(0, 0, 0, 0, 1, 0, v);
      cyc(0, 1, 0, 0, 0, 0, (v * 7) % 32);
      chk("R1", 2, int'(tap_o[2]), (v * 7) % 32);
      cyc(0, 0, 1, v % 2, 0, 0, 0);
      cyc(0, 0, 0, ~v % 2, 1, 0, 31 - v);
    end
    // R4 wrap runs in both directions
    for (int i = 0; i < 40; i++) cyc(0, 0, 1, 1, 0, 0, i % 32);
    for (int i = 0; i < 70; i++) cyc(0, 0, 1, 0, 0, 0, i % 32);
    // R5 load beats step
    cyc(0, 1, 1, 1, 0, 0, 12);
    cyc(0, 1, 1, 0, 0, 0, 0);
    // R8 same-cycle stage and load commits the old staged value
    cyc(0, 0, 0, 0, 1, 0, 20);
    cyc(0, 1, 0, 0, 1, 0, 25);
    chk("R8", 3, int'(tap_o[3]), 20);
    cyc(0, 1, 0, 0, 0, 0, 3);
    chk("R8", 3, int'(tap_o[3]), 25);
    // R9 clear wins over stage load
    cyc(0, 0, 0, 0, 1, 1, 17);
    cyc(0, 1, 0, 0, 0, 0, 4);
    chk("R9", 3, int'(tap_o[3]), 0);
    // R11 reset clears staging
    cyc(0, 0, 0, 0, 1, 0, 30);
    cyc(1, 0, 1, 1, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 6);
    chk("R11", 3, int'(tap_o[3]), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule